// File: doc/BRIEF.md
# Linked-Page Transmit Record Fetcher

This block pulls outgoing message records from a host memory area that is cut into fixed-size pages. The host places records one after another inside a page and rings a doorbell for each frame it places. The doorbell value is added to a pending-frame count. While that count is non-zero, the fetcher reads the record header at its read pointer. It checks the header, then either streams the whole record out on a valid/ready interface or, for a link record, jumps to the page address that the record carries.

A link jump raises a one-cycle link event, so that the host knows the page it just left can be refilled. A level control input holds the fetcher idle and clears its state. When that input drops, fetching starts from a 64-bit base address that the host writes as two 32-bit halves. Memory is read one 32-bit word at a time through a request/response port with at most one read in flight.

Top module: `tpf_fetch`

## Requirements
- R1: While `tx_hold` is 1 the block issues no reads, presents no output word, raises no link event, clears `fetch_err`, and forces the pending-frame count to zero, so doorbells written during hold are lost.
- R2: On the first cycle after `tx_hold` falls, the read pointer loads the base address, whose low half is written with `cfg_we`=1, `cfg_hi`=0 and whose high half is written with `cfg_hi`=1. The first read then goes to that address.
- R3: A doorbell write (`db_we`=1) adds `db_data` to the pending-frame count, saturating at its maximum. Each message record that is fully streamed removes one. No header read is issued while the count is zero.
- R4: A record header word holds the byte size in bits 15:0 and the type in bits 31:16. A message record is streamed as ceil(size/4) words: the header word first with `tx_sop`=1, and `tx_eop`=1 on its last word.
- R5: Record words are read at consecutive word addresses. The next record header is read at the record start plus the size rounded up to a multiple of 4.
- R6: A record of type 0x1001 and size 12 is a link. Its words at +4 (low half) and +8 (high half) give the next read address, `link_evt` pulses for one cycle, nothing is streamed and the pending count is unchanged.
- R7: A header with size 0, a link type with size other than 12, or a rounded size that runs past the end of the current 2 KB page (default `PAGE_BYTES`) sets `fetch_err`. Nothing of that record is streamed, no further reads are issued, and `fetch_err` stays set until `tx_hold` is asserted.
- R8: While `tx_valid` is 1 and `tx_ready` is 0, `tx_data`, `tx_sop` and `tx_eop` hold their values.
- R9: A new read is not requested until the previous read has returned `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_hold | input | 1 | Holds the fetcher idle while 1 |
| cfg_we | input | 1 | Base address half write strobe |
| cfg_hi | input | 1 | 0 selects the low half, 1 the high half |
| cfg_data | input | 32 | Base address half value |
| db_we | input | 1 | Doorbell write strobe |
| db_data | input | 32 | Frames added to the pending count |
| mem_req | output | 1 | Word read request, one-cycle pulse |
| mem_addr | output | ADDR_W | Byte address of the word read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| tx_valid | output | 1 | Output word valid |
| tx_ready | input | 1 | Output word accepted |
| tx_data | output | 32 | Output record word |
| tx_sop | output | 1 | First word of a record |
| tx_eop | output | 1 | Last word of a record |
| link_evt | output | 1 | One-cycle pulse on a consumed link record |
| fetch_err | output | 1 | Sticky malformed-record flag |

## Verification
The bench fills three pages with records of random sizes from 1 to 64 bytes and chains them with two links. Directed sizes of 1, 4 and 5 bytes tell apart the ceiling rounding from plain truncation, and a final record that ends exactly at a page end separates a legal fit from an overrun. Doorbells come first as a batch of three and then as a mix of 1s and 2s, which shows that fetching stops at the pending count and not at the end of memory. A doorbell rung during hold shows that hold clears the count. Random read latency and random back-pressure vary the timing of every handshake. Three malformed headers (zero size, page overrun, short link) each must stop the fetcher without streaming any of the bad record.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
  localparam logic [15:0] LINK_TYPE = 16'h1001;
  localparam logic [15:0] LINK_SIZE = 16'd12;

  typedef enum logic [2:0] {S_HOLD, S_WAIT, S_RSP, S_OUT, S_ERR} wstate_t;
  typedef enum logic [1:0] {P_HDR, P_LLO, P_LHI, P_DAT} phase_t;
endpackage

// File: rtl/tpf_pend_ctr.sv
module tpf_pend_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add_en,
  input  logic [31:0]      add_val,
  input  logic             dec,
  output logic             nz
);
  localparam logic [32:0] MAXV = 33'((64'd1 << CNT_W) - 64'd1);

  logic [CNT_W-1:0] count;
  logic [32:0]      wide;

  always_comb begin
    wide = 33'(count) + (add_en ? {1'b0, add_val} : 33'd0) - 33'(dec);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)     count <= '0;
    else if (wide > MAXV) count <= MAXV[CNT_W-1:0];
    else                count <= wide[CNT_W-1:0];
  end

  assign nz = (count != '0);
endmodule

// File: rtl/tpf_hdr_chk.sv
module tpf_hdr_chk
  import tpf_pkg::*;
#(
  parameter int PG_W = 11
) (
  input  logic [31:0]     hdr,
  input  logic [PG_W-1:0] offset,
  output logic            is_link,
  output logic            bad,
  output logic [16:0]     rsize,
  output logic [14:0]     nwords
);
  localparam logic [17:0] PAGE_END = 18'(2 ** PG_W);

  logic [15:0] sz;
  logic [15:0] typ;
  logic [17:0] end_pos;

  assign sz      = hdr[15:0];
  assign typ     = hdr[31:16];
  assign rsize   = ({1'b0, sz} + 17'd3) & ~17'd3;
  assign nwords  = rsize[16:2];
  assign end_pos = 18'(offset) + {1'b0, rsize};
  assign is_link = (typ == LINK_TYPE);
  assign bad     = (sz == 16'd0) || (end_pos > PAGE_END) ||
                   (is_link && (sz != LINK_SIZE));
endmodule

// File: rtl/tpf_walker.sv
module tpf_walker
  import tpf_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic [ADDR_W-1:0] base,
  input  logic              pend_nz,
  output logic              dec,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [31:0]       tx_data,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic              link_evt,
  output logic              fetch_err
);
  localparam int PG_W = $clog2(PAGE_BYTES);

  wstate_t           state;
  phase_t            phase;
  logic [ADDR_W-1:0] ptr;
  logic [14:0]       widx;
  logic [14:0]       nwords_q;
  logic [16:0]       rsize_q;
  logic [31:0]       lo_q;
  logic [63:0]       lnk_addr;

  logic              h_link, h_bad;
  logic [16:0]       h_rsize;
  logic [14:0]       h_nwords;

  tpf_hdr_chk #(.PG_W(PG_W)) i_chk (
    .hdr(mem_rdata), .offset(ptr[PG_W-1:0]),
    .is_link(h_link), .bad(h_bad), .rsize(h_rsize), .nwords(h_nwords)
  );

  assign lnk_addr = {mem_rdata, lo_q};
  assign dec = (state == S_OUT) && tx_valid && tx_ready && tx_eop;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      state     <= S_HOLD;
      phase     <= P_HDR;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
      tx_sop    <= 1'b0;
      tx_eop    <= 1'b0;
      link_evt  <= 1'b0;
      fetch_err <= 1'b0;
      ptr       <= '0;
      widx      <= '0;
      nwords_q  <= '0;
      rsize_q   <= '0;
      lo_q      <= '0;
    end else begin
      mem_req  <= 1'b0;
      link_evt <= 1'b0;
      case (state)
        S_HOLD: begin
          ptr   <= base;
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (pend_nz) begin
            mem_req  <= 1'b1;
            mem_addr <= ptr;
            phase    <= P_HDR;
            state    <= S_RSP;
          end
        end
        S_RSP: begin
          if (mem_rvalid) begin
            case (phase)
              P_HDR: begin
                if (h_bad) begin
                  fetch_err <= 1'b1;
                  state     <= S_ERR;
                end else if (h_link) begin
                  mem_req  <= 1'b1;
                  mem_addr <= ptr + ADDR_W'(4);
                  phase    <= P_LLO;
                end else begin
                  tx_valid <= 1'b1;
                  tx_data  <= mem_rdata;
                  tx_sop   <= 1'b1;
                  tx_eop   <= (h_nwords == 15'd1);
                  rsize_q  <= h_rsize;
                  nwords_q <= h_nwords;
                  widx     <= 15'd1;
                  state    <= S_OUT;
                end
              end
              P_LLO: begin
                lo_q     <= mem_rdata;
                mem_req  <= 1'b1;
                mem_addr <= ptr + ADDR_W'(8);
                phase    <= P_LHI;
              end
              P_LHI: begin
                ptr      <= lnk_addr[ADDR_W-1:0];
                link_evt <= 1'b1;
                state    <= S_WAIT;
              end
              default: begin
                tx_valid <= 1'b1;
                tx_data  <= mem_rdata;
                tx_sop   <= 1'b0;
                tx_eop   <= (widx == nwords_q - 15'd1);
                widx     <= widx + 15'd1;
                state    <= S_OUT;
              end
            endcase
          end
        end
        S_OUT: begin
          if (tx_ready) begin
            tx_valid <= 1'b0;
            if (tx_eop) begin
              ptr   <= ptr + ADDR_W'(rsize_q);
              state <= S_WAIT;
            end else begin
              mem_req  <= 1'b1;
              mem_addr <= ptr + ADDR_W'({widx, 2'b00});
              phase    <= P_DAT;
              state    <= S_RSP;
            end
          end
        end
        default: state <= S_ERR;
      endcase
    end
  end
endmodule

// File: rtl/tpf_fetch.sv
module tpf_fetch #(
  parameter int ADDR_W     = 64,
  parameter int PAGE_BYTES = 2048,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_hold,
  input  logic              cfg_we,
  input  logic              cfg_hi,
  input  logic [31:0]       cfg_data,
  input  logic              db_we,
  input  logic [31:0]       db_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [31:0]       tx_data,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic              link_evt,
  output logic              fetch_err
);
  logic [63:0] base_q;
  logic        pend_nz;
  logic        dec;

  always_ff @(posedge clk) begin
    if (rst) base_q <= '0;
    else if (cfg_we) begin
      if (cfg_hi) base_q[63:32] <= cfg_data;
      else        base_q[31:0]  <= cfg_data;
    end
  end

  tpf_pend_ctr #(.CNT_W(CNT_W)) i_pend (
    .clk(clk), .rst(rst), .clr(tx_hold),
    .add_en(db_we), .add_val(db_data), .dec(dec), .nz(pend_nz)
  );

  tpf_walker #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) i_walk (
    .clk(clk), .rst(rst), .hold(tx_hold), .base(base_q[ADDR_W-1:0]),
    .pend_nz(pend_nz), .dec(dec),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop),
    .link_evt(link_evt), .fetch_err(fetch_err)
  );
endmodule

// File: rtl/tpf_fetch_chk.sv
module tpf_fetch_chk (
  input logic        clk,
  input logic        rst,
  input logic        tx_hold,
  input logic        mem_req,
  input logic        mem_rvalid,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [31:0] tx_data,
  input logic        tx_sop,
  input logic        tx_eop,
  input logic        link_evt,
  input logic        fetch_err
);
  logic busy;
  logic in_rec;

  always_ff @(posedge clk) begin
    if (rst) busy <= 1'b0;
    else     busy <= (busy || mem_req) && !mem_rvalid;
  end

  always_ff @(posedge clk) begin
    if (rst || tx_hold) in_rec <= 1'b0;
    else if (tx_valid && tx_ready) in_rec <= !tx_eop;
  end

  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (rst)
    tx_hold |=> (!mem_req && !tx_valid && !link_evt && !fetch_err));

  assert_sop_marks_R4: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (tx_sop == !in_rec));

  assert_link_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    link_evt |=> !link_evt);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (fetch_err && !tx_hold) |=> fetch_err);

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    fetch_err |-> (!mem_req && !tx_valid));

  assert_tx_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));

  assert_one_read_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !busy);
endmodule

bind tpf_fetch tpf_fetch_chk i_fetch_chk (.*);

// File: tb/test_tpf_fetch.sv
module test_tpf_fetch;
  localparam logic [63:0] MEM_BASE = 64'h0000_0003_4000_0000;
  localparam int MEM_WORDS = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_hold = 1'b1;
  logic        cfg_we = 1'b0, cfg_hi = 1'b0;
  logic [31:0] cfg_data = '0;
  logic        db_we = 1'b0;
  logic [31:0] db_data = '0;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        tx_valid, tx_sop, tx_eop, link_evt, fetch_err;
  logic        tx_ready = 1'b0;
  logic [31:0] tx_data;

  tpf_fetch i_tpf_fetch (
    .clk(clk), .rst(rst), .tx_hold(tx_hold),
    .cfg_we(cfg_we), .cfg_hi(cfg_hi), .cfg_data(cfg_data),
    .db_we(db_we), .db_data(db_data),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop),
    .link_evt(link_evt), .fetch_err(fetch_err)
  );

  always #5 clk = ~clk;

  logic [31:0] mem [0:MEM_WORDS-1];
  logic [33:0] exp_q [$];
  int n_chk = 0, n_fail = 0;
  int rec_done = 0, req_cnt = 0, link_cnt = 0, frames = 0;
  bit armed = 1'b0, finished = 1'b0;
  logic [63:0] first_addr = '0;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int unsigned round4(input int unsigned s);
    return (s + 3) & ~32'd3;
  endfunction

  // R4 R5: message record built in memory, expected stream queued
  task automatic put_msg(input int unsigned rel, input int unsigned sz);
    int unsigned nw = (sz + 3) / 4;
    logic [15:0] typ = 16'($urandom_range(0, 16'h0fff));
    for (int unsigned k = 0; k < nw; k++) begin
      logic [31:0] w = (k == 0) ? {typ, 16'(sz)} : $urandom;
      mem[(rel >> 2) + k] = w;
      exp_q.push_back({(k == 0), (k == nw - 1), w});
    end
    frames++;
  endtask

  // R6: link record pointing at a page start
  task automatic put_link(input int unsigned rel, input int unsigned target);
    logic [63:0] a = MEM_BASE + 64'(target);
    mem[rel >> 2]       = {16'h1001, 16'd12};
    mem[(rel >> 2) + 1] = a[31:0];
    mem[(rel >> 2) + 2] = a[63:32];
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_base(input logic [63:0] a);
    @(negedge clk); cfg_we = 1; cfg_hi = 0; cfg_data = a[31:0];
    @(negedge clk); cfg_hi = 1; cfg_data = a[63:32];
    @(negedge clk); cfg_we = 0; cfg_hi = 0;
  endtask

  task automatic ring(input int v);
    @(negedge clk); db_we = 1; db_data = 32'(v);
    @(negedge clk); db_we = 0; db_data = 0;
  endtask

  task automatic wait_recs(input int target);
    int c = 0;
    while (rec_done < target && c < 40000) begin @(negedge clk); c++; end
  endtask

  // memory responder: one outstanding read, latency 0..2 extra cycles
  initial begin
    int lat = 0;
    bit act = 0;
    logic [63:0] rel;
    forever begin
      @(negedge clk);
      mem_rvalid = 0;
      if (act) begin
        lat--;
        if (lat == 0) begin
          act = 0; mem_rvalid = 1; mem_rdata = mem[rel[13:2]];
        end
      end else if (mem_req) begin
        rel = mem_addr - MEM_BASE;
        if (rel >= 64'(MEM_WORDS * 4))
          check(0, "R5 read outside window", mem_addr, MEM_BASE);
        lat = $urandom_range(0, 2);
        if (lat == 0) begin mem_rvalid = 1; mem_rdata = mem[rel[13:2]]; end
        else act = 1;
      end
    end
  end

  // monitors
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        req_cnt++;
        if (armed) begin first_addr = mem_addr; armed = 0; end
      end
      if (link_evt) link_cnt++;
    end
  end

  // sink with random back-pressure
  initial begin
    logic [33:0] e;
    forever begin
      @(negedge clk);
      tx_ready = ($urandom_range(0, 3) != 0);
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) check(0, "R4 unexpected word", {tx_sop, tx_eop, tx_data}, 0);
        else begin
          e = exp_q.pop_front();
          check({tx_sop, tx_eop, tx_data} == e, "R4 R5 stream word",
                {tx_sop, tx_eop, tx_data}, e);
        end
        if (tx_eop) rec_done++;
      end
    end
  end

  task automatic run_err(input int unsigned rel, input logic [31:0] hdr, input string tag);
    int r, d;
    @(negedge clk); tx_hold = 1;
    cycles(3);
    check(fetch_err == 0, "R1 hold clears error", fetch_err, 0);
    set_base(MEM_BASE + 64'(rel));
    mem[rel >> 2] = hdr;
    @(negedge clk); tx_hold = 0;
    d = rec_done;
    ring(1);
    cycles(40);
    check(fetch_err == 1, {"R7 error on ", tag}, fetch_err, 1);
    r = req_cnt;
    cycles(20);
    check(req_cnt == r, "R7 no reads after error", req_cnt, r);
    check(fetch_err == 1, "R7 error sticky", fetch_err, 1);
    check(rec_done == d && exp_q.size() == 0, "R7 nothing streamed", rec_done, d);
  endtask

  initial begin
    int unsigned rel, sz;
    int left, r;
    void'($urandom(32'd4711));
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
    cycles(4);
    rst = 0;
    @(negedge clk);
    check(!mem_req && !tx_valid && !link_evt && !fetch_err, "R1 reset state",
          {mem_req, tx_valid, link_evt, fetch_err}, 0);

    // page 0: random fill up to the end, then link to page 1
    rel = 0;
    forever begin
      sz = $urandom_range(1, 64);
      if (rel + round4(sz) + 12 > 2048) break;
      put_msg(rel, sz); rel += round4(sz);
    end
    put_link(rel, 2048);
    // page 1: directed rounding sizes, then link to page 2
    rel = 2048;
    put_msg(rel, 1); rel += 4;
    put_msg(rel, 4); rel += 4;
    put_msg(rel, 5); rel += 8;
    for (int k = 0; k < 3; k++) begin
      sz = $urandom_range(1, 64); put_msg(rel, sz); rel += round4(sz);
    end
    put_link(rel, 4096);
    // page 2: a few records and one that ends exactly at the page end
    rel = 4096;
    for (int k = 0; k < 4; k++) begin
      sz = $urandom_range(1, 64); put_msg(rel, sz); rel += round4(sz);
    end
    put_msg(rel, 6144 - rel);

    set_base(MEM_BASE);
    ring(7);                       // lost: hold clears the count (R1)
    armed = 1;
    @(negedge clk); tx_hold = 0;
    cycles(30);
    check(req_cnt == 0, "R1 R3 doorbell during hold ignored", req_cnt, 0);

    ring(3);
    wait_recs(3);
    cycles(30);
    check(rec_done == 3, "R3 stops at pending count", rec_done, 3);
    check(first_addr == MEM_BASE, "R2 first read at base", first_addr, MEM_BASE);
    r = req_cnt;
    cycles(30);
    check(req_cnt == r, "R3 no read while count zero", req_cnt, r);

    left = frames - 3;
    while (left > 0) begin
      int v = (left >= 2) ? $urandom_range(1, 2) : 1;
      ring(v); left -= v;
      cycles($urandom_range(0, 6));
    end
    wait_recs(frames);
    cycles(30);
    check(rec_done == frames, "R3 R4 all records streamed", rec_done, frames);
    check(exp_q.size() == 0, "R5 expected stream consumed", exp_q.size(), 0);
    check(link_cnt == 2, "R6 one event per link", link_cnt, 2);
    r = req_cnt;
    cycles(30);
    check(req_cnt == r, "R3 idle after exact page fit", req_cnt, r);

    run_err(6144, {16'h0007, 16'd0}, "zero size");
    run_err(6144 + 2040, {16'h0003, 16'd12}, "page overrun");
    run_err(6144 + 100, {16'h1001, 16'd8}, "short link");
    check(link_cnt == 2, "R6 bad link raises no event", link_cnt, 2);

    @(negedge clk); tx_hold = 1;
    cycles(2);
    check(fetch_err == 0 && !mem_req && !tx_valid, "R1 hold clears sticky error",
          fetch_err, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule